// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block is the refill engine behind a hardware-managed translation cache. When a lookup misses, the block receives the 32-bit virtual address together with the frame number of the root table. It then walks two levels of page tables held in memory and returns the physical address along with the leaf entry. If either level holds an invalid entry, it returns a fault with a cause code instead.

The virtual address has three fields. The top field indexes the root table. The middle field indexes the secondary table. The low 12 bits are the byte offset within a 4 KB page. Every table entry is one 4-byte word, so each table holds 1024 entries and fills exactly one page.

Reads go out on a single-word memory port, one at a time. The root entry is always read first and the secondary entry second. The block handles one walk at a time and reports its end with a single-cycle pulse.

Top module: `pt_walker`

## Requirements
- R1: The virtual address is decoded as root index = vaddr[31:22], secondary index = vaddr[21:12] and page offset = vaddr[11:0]. Indices 0 and 1023 at either level are both reachable.
- R2: After a request is accepted, the next cycle raises mem_req_o with the root entry address {root_frame_i, vaddr[31:22], 2'b00}. The root frame sampled with the request chooses the table.
- R3: The secondary read has address {root_entry[31:12], vaddr[21:12], 2'b00}. It is issued only after the root read data has returned. Only one read is outstanding at a time. mem_req_o and mem_addr_o hold steady until mem_rvalid_i is seen.
- R4: On success, done_o pulses with paddr_o = {leaf_entry[31:12], vaddr[11:0]} and pte_o = leaf_entry. fault_cause_o is 2'b00 in that cycle.
- R5: Entry format: bit 0 = valid, bit 1 = read, bit 2 = write, bit 3 = execute, bits 31:12 = frame number, bits 11:4 reserved. Permission bits are passed through unchanged in pte_o. Reserved and permission bits at either level do not change any address.
- R6: An invalid root entry (bit 0 = 0) ends the walk with a fault_o pulse and fault_cause_o = 2'b01. No secondary read is issued, paddr_o is 0 and pte_o holds the invalid entry.
- R7: An invalid secondary entry ends the walk with a fault_o pulse and fault_cause_o = 2'b10. paddr_o is 0.
- R8: done_o and fault_o are single-cycle pulses and never occur together. busy_o is high from the cycle after acceptance until the pulse, and is low in the pulse cycle.
- R9: req_valid_i is ignored while busy_o is high. The running walk, its read addresses and its result are unchanged, and no further walk starts after it.
- R10: After reset, busy_o, mem_req_o, done_o and fault_o are 0, and fault_cause_o and paddr_o are 0.
- R11: Any memory latency is accepted, including mem_rvalid_i in the same cycle that mem_req_o first rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request, sampled while idle |
| req_vaddr_i | input | 32 | Virtual address to translate |
| root_frame_i | input | 20 | Frame number of the root table |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | Memory read request, held until read data is valid |
| mem_addr_o | output | 32 | Byte address of the entry being read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data word |
| done_o | output | 1 | Single-cycle translation success pulse |
| fault_o | output | 1 | Single-cycle fault pulse |
| fault_cause_o | output | 2 | 00 none, 01 root entry invalid, 10 secondary entry invalid |
| paddr_o | output | 32 | Translated physical address, 0 on fault |
| pte_o | output | 32 | Last entry read: the leaf on success, the invalid entry on fault |

## Verification
The assertions check several properties on every cycle: a read request holds its address until data returns, a new read can only begin from an accepted idle request, the result pulses are single-cycle and mutually exclusive, busy is low during a pulse, and a fault always carries a nonzero cause with a zero address. Some properties can only be shown by the bench's scenarios, which compare against its own table model: the exact root and secondary read addresses, the absence of a second read after a root fault, the assembled physical address, the fact that reserved bits do not change the address, the handling of indices at 0 and 1023, and the effect of requests sent while busy.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int unsigned LEVELS = 2;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_L1   = 2'b01,
    CAUSE_L2   = 2'b10
  } cause_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_L1   = 2'b01,
    ST_L2   = 2'b10
  } walk_state_e;

  localparam int unsigned PTE_V_BIT = 0;
  localparam int unsigned PTE_R_BIT = 1;
  localparam int unsigned PTE_W_BIT = 2;
  localparam int unsigned PTE_X_BIT = 3;
endpackage

// File: rtl/pt_va_split.sv
module pt_va_split #(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned LEVELS = 2
) (
  input  logic [VA_W-1:0]  vaddr_i,
  output logic [IDX_W-1:0] idx_o [LEVELS],
  output logic [OFF_W-1:0] off_o
);
  // level 0 is the root, taken from the top bits
  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int unsigned LO = OFF_W + (LEVELS - 1 - l) * IDX_W;
    assign idx_o[l] = vaddr_i[LO +: IDX_W];
  end
  assign off_o = vaddr_i[OFF_W-1:0];
endmodule

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
  parameter int unsigned PA_W      = 32,
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned IDX_W     = 10,
  parameter int unsigned ENT_SHIFT = 2,
  localparam int unsigned FRAME_W  = PA_W - OFF_W
) (
  input  logic [FRAME_W-1:0] base_frame_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [PA_W-1:0]    addr_o
);
  logic [PA_W-1:0] base_w, ofs_w;
  assign base_w = {base_frame_i, {OFF_W{1'b0}}};
  assign ofs_w  = PA_W'(idx_i) << ENT_SHIFT;
  assign addr_o = base_w + ofs_w;
endmodule

// File: rtl/pt_pte_decode.sv
module pt_pte_decode
  import pt_walker_pkg::*;
#(
  parameter int unsigned PA_W     = 32,
  parameter int unsigned OFF_W    = 12,
  localparam int unsigned FRAME_W = PA_W - OFF_W
) (
  input  logic [PA_W-1:0]    pte_i,
  output logic               valid_o,
  output logic [2:0]         perm_o,
  output logic [FRAME_W-1:0] frame_o
);
  assign valid_o = pte_i[PTE_V_BIT];
  assign perm_o  = {pte_i[PTE_X_BIT], pte_i[PTE_W_BIT], pte_i[PTE_R_BIT]};
  assign frame_o = pte_i[PA_W-1:OFF_W];
endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walker_pkg::*;
#(
  parameter int unsigned VA_W     = 32,
  parameter int unsigned PA_W     = 32,
  parameter int unsigned OFF_W    = 12,
  localparam int unsigned FRAME_W = PA_W - OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [VA_W-1:0]    req_vaddr_i,
  input  logic [FRAME_W-1:0] root_frame_i,
  input  logic               rvalid_i,
  input  logic [PA_W-1:0]    rdata_i,
  input  logic               ent_valid_i,
  input  logic [FRAME_W-1:0] ent_frame_i,
  output logic               active_o,
  output logic               leaf_lvl_o,
  output logic [VA_W-1:0]    va_o,
  output logic [FRAME_W-1:0] base_frame_o,
  output logic               done_o,
  output logic               fault_o,
  output cause_e             cause_o,
  output logic [PA_W-1:0]    paddr_o,
  output logic [PA_W-1:0]    pte_o
);
  walk_state_e        state_q;
  logic [VA_W-1:0]    va_q;
  logic [FRAME_W-1:0] base_q;
  logic               done_q, fault_q;
  cause_e             cause_q;
  logic [PA_W-1:0]    paddr_q, pte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      base_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      cause_q <= CAUSE_NONE;
      paddr_q <= '0;
      pte_q   <= '0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            va_q    <= req_vaddr_i;
            base_q  <= root_frame_i;
            state_q <= ST_L1;
          end
        end
        ST_L1: begin
          if (rvalid_i) begin
            if (ent_valid_i) begin
              base_q  <= ent_frame_i;
              state_q <= ST_L2;
            end else begin
              fault_q <= 1'b1;
              cause_q <= CAUSE_L1;
              paddr_q <= '0;
              pte_q   <= rdata_i;
              state_q <= ST_IDLE;
            end
          end
        end
        ST_L2: begin
          if (rvalid_i) begin
            pte_q   <= rdata_i;
            state_q <= ST_IDLE;
            if (ent_valid_i) begin
              done_q  <= 1'b1;
              cause_q <= CAUSE_NONE;
              paddr_q <= {ent_frame_i, va_q[OFF_W-1:0]};
            end else begin
              fault_q <= 1'b1;
              cause_q <= CAUSE_L2;
              paddr_q <= '0;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign active_o     = (state_q != ST_IDLE);
  assign leaf_lvl_o   = (state_q == ST_L2);
  assign va_o         = va_q;
  assign base_frame_o = base_q;
  assign done_o       = done_q;
  assign fault_o      = fault_q;
  assign cause_o      = cause_q;
  assign paddr_o      = paddr_q;
  assign pte_o        = pte_q;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PA_W      = 32,
  parameter int unsigned IDX_W     = 10,
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned ENT_BYTES = 4,
  localparam int unsigned FRAME_W   = PA_W - OFF_W,
  localparam int unsigned ENT_SHIFT = $clog2(ENT_BYTES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [VA_W-1:0]    req_vaddr_i,
  input  logic [FRAME_W-1:0] root_frame_i,
  output logic               busy_o,
  output logic               mem_req_o,
  output logic [PA_W-1:0]    mem_addr_o,
  input  logic               mem_rvalid_i,
  input  logic [PA_W-1:0]    mem_rdata_i,
  output logic               done_o,
  output logic               fault_o,
  output logic [1:0]         fault_cause_o,
  output logic [PA_W-1:0]    paddr_o,
  output logic [PA_W-1:0]    pte_o
);
  logic [IDX_W-1:0]   idx_w [LEVELS];
  logic [OFF_W-1:0]   off_w;
  logic [IDX_W-1:0]   cur_idx;
  logic [VA_W-1:0]    va_w;
  logic [FRAME_W-1:0] base_w, ent_frame_w;
  logic               active_w, leaf_w, ent_valid_w;
  logic [2:0]         ent_perm_w;
  cause_e             cause_w;

  pt_va_split #(.VA_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .LEVELS(LEVELS)) u_split (
    .vaddr_i (va_w),
    .idx_o   (idx_w),
    .off_o   (off_w)
  );

  assign cur_idx = leaf_w ? idx_w[1] : idx_w[0];

  pt_entry_addr #(.PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENT_SHIFT(ENT_SHIFT)) u_addr (
    .base_frame_i (base_w),
    .idx_i        (cur_idx),
    .addr_o       (mem_addr_o)
  );

  pt_pte_decode #(.PA_W(PA_W), .OFF_W(OFF_W)) u_dec (
    .pte_i   (mem_rdata_i),
    .valid_o (ent_valid_w),
    .perm_o  (ent_perm_w),
    .frame_o (ent_frame_w)
  );

  pt_walk_ctrl #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_vaddr_i  (req_vaddr_i),
    .root_frame_i (root_frame_i),
    .rvalid_i     (mem_rvalid_i),
    .rdata_i      (mem_rdata_i),
    .ent_valid_i  (ent_valid_w),
    .ent_frame_i  (ent_frame_w),
    .active_o     (active_w),
    .leaf_lvl_o   (leaf_w),
    .va_o         (va_w),
    .base_frame_o (base_w),
    .done_o       (done_o),
    .fault_o      (fault_o),
    .cause_o      (cause_w),
    .paddr_o      (paddr_o),
    .pte_o        (pte_o)
  );

  // permissions reach the requester through pte_o only
  logic unused_w;
  assign unused_w = ^{ent_perm_w, off_w};

  assign busy_o        = active_w;
  assign mem_req_o     = active_w;
  assign fault_cause_o = cause_w;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int unsigned PA_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            busy_o,
  input logic            mem_req_o,
  input logic [PA_W-1:0] mem_addr_o,
  input logic            mem_rvalid_i,
  input logic            done_o,
  input logic            fault_o,
  input logic [1:0]      fault_cause_o,
  input logic [PA_W-1:0] paddr_o,
  input logic [PA_W-1:0] pte_o
);
  a_r3_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));

  a_r2_read_from_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> $past(req_valid_i) && !$past(busy_o));

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_fault_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> !fault_o);

  a_r8_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o));

  a_r8_idle_on_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fault_o) |-> !busy_o);

  a_r4_done_leaf_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> pte_o[0] && fault_cause_o == 2'b00);

  a_r6_r7_fault_no_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> paddr_o == '0 && (fault_cause_o == 2'b01 || fault_cause_o == 2'b10));

  a_r6_root_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o && fault_cause_o == 2'b01 |-> !pte_o[0]);
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .busy_o        (busy_o),
  .mem_req_o     (mem_req_o),
  .mem_addr_o    (mem_addr_o),
  .mem_rvalid_i  (mem_rvalid_i),
  .done_o        (done_o),
  .fault_o       (fault_o),
  .fault_cause_o (fault_cause_o),
  .paddr_o       (paddr_o),
  .pte_o         (pte_o)
);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [19:0] root_frame = '0;
  logic        busy, mem_req, mem_rvalid, done, fault;
  logic [31:0] mem_addr, mem_rdata, paddr, pte;
  logic [1:0]  cause;

  always #2.5 clk = ~clk;

  pt_walker u_pt_walker (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_vaddr_i(req_vaddr),
    .root_frame_i(root_frame), .busy_o(busy), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .done_o(done), .fault_o(fault),
    .fault_cause_o(cause), .paddr_o(paddr), .pte_o(pte)
  );

  typedef struct {
    bit          flt;
    logic [1:0]  cause;
    logic [31:0] pa;
    logic [31:0] pte;
  } exp_t;

  int          checks = 0, errors = 0, results_seen = 0;
  exp_t        exp_q[$];
  logic [31:0] addr_q[$];
  logic [31:0] mem [logic [31:0]];
  int          lat = 0, wait_cnt = 0;
  bit          prev_pulse = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic set_pte(input logic [19:0] frame, input int idx, input logic [31:0] v);
    mem[{frame, 12'h0} + 32'(idx * 4)] = v;
  endtask

  // memory model: latency counted in cycles while the request is up
  always @(negedge clk) begin
    mem_rvalid <= 1'b0;
    if (rst_n && mem_req) begin
      if (wait_cnt >= lat) begin
        if (addr_q.size() == 0) begin
          chk(0, "R3/R6 unexpected read", mem_addr, 32'h0);
        end else begin
          logic [31:0] ea;
          ea = addr_q.pop_front();
          chk(mem_addr == ea, "R2/R3 read address", mem_addr, ea);
        end
        mem_rdata  <= rd(mem_addr);
        mem_rvalid <= 1'b1;
        wait_cnt   = 0;
      end else begin
        wait_cnt++;
      end
    end else begin
      wait_cnt = 0;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && (done || fault)) begin
      chk(!(done && fault), "R8 exclusive", {31'h0, fault}, 32'h0);
      chk(!busy, "R8 busy low on pulse", {31'h0, busy}, 32'h0);
      chk(!prev_pulse, "R8 single cycle", 32'h1, 32'h0);
      if (exp_q.size() == 0) begin
        chk(0, "R9 unexpected result", paddr, 32'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(fault == e.flt, e.flt ? "R6/R7 fault flag" : "R4 done flag", {31'h0, fault}, {31'h0, e.flt});
        chk(cause == e.cause, "R6/R7 cause", {30'h0, cause}, {30'h0, e.cause});
        chk(paddr == e.pa, "R4 paddr", paddr, e.pa);
        chk(pte == e.pte, "R4/R5 pte", pte, e.pte);
      end
      results_seen++;
    end
    prev_pulse = rst_n && (done || fault);
  end

  task automatic walk(input logic [31:0] va, input logic [19:0] root, input int l, input bit poke);
    logic [31:0] a1, a2, e1, e2;
    exp_t e;
    int start, t;
    lat = l;
    a1 = {root, va[31:22], 2'b00};
    e1 = rd(a1);
    addr_q.push_back(a1);
    if (!e1[0]) begin
      e = '{1'b1, 2'b01, 32'h0, e1};
    end else begin
      a2 = {e1[31:12], va[21:12], 2'b00};
      e2 = rd(a2);
      addr_q.push_back(a2);
      if (e2[0]) e = '{1'b0, 2'b00, {e2[31:12], va[11:0]}, e2};
      else       e = '{1'b1, 2'b10, 32'h0, e2};
    end
    exp_q.push_back(e);
    start = results_seen;
    req_vaddr  = va;
    root_frame = root;
    req_valid  = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy, "R8 busy after accept", {31'h0, busy}, 32'h1);
    if (poke) begin
      // R9: new requests while busy must be dropped
      req_vaddr  = ~va;
      root_frame = ~root;
      req_valid  = 1'b1;
      repeat (2) @(negedge clk);
      req_valid = 1'b0;
    end
    t = 0;
    while (results_seen == start && t < 200) begin
      @(negedge clk);
      t++;
    end
    chk(results_seen != start, "R8 walk ended", 32'(t), 32'h0);
    repeat (3) @(negedge clk);
    chk(addr_q.size() == 0, "R3/R6 read count", 32'(addr_q.size()), 32'h0);
    addr_q.delete();
    chk(!busy && !mem_req, "R9 stays idle", {30'h0, busy, mem_req}, 32'h0);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    // root at frame 0x10
    set_pte(20'h00010, 1,    32'h00020_001);
    set_pte(20'h00020, 3,    32'hABCDE_007);
    set_pte(20'h00020, 4,    32'h12345_006);
    set_pte(20'h00010, 5,    32'h00021_FFF);
    set_pte(20'h00021, 1023, 32'hFFFFF_FF9);
    set_pte(20'h00010, 1023, 32'h00022_001);
    set_pte(20'h00022, 0,    32'h00001_00B);
    // second root at frame 0x30
    set_pte(20'h00030, 1,    32'h00040_001);
    set_pte(20'h00040, 3,    32'h0BEEF_003);

    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy && !mem_req, "R10 busy/req", {30'h0, busy, mem_req}, 32'h0);
    chk(!done && !fault, "R10 pulses", {30'h0, done, fault}, 32'h0);
    chk(cause == 2'b00 && paddr == 32'h0, "R10 cause/paddr", paddr, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    walk({10'd1, 10'd3, 12'h5A4}, 20'h00010, 0, 0);    // R1 R2 R3 R4 R11 zero wait
    walk({10'd1, 10'd3, 12'h001}, 20'h00010, 3, 0);    // R11 latency
    walk({10'd2, 10'd3, 12'h010}, 20'h00010, 1, 0);    // R6 root invalid
    walk({10'd1, 10'd4, 12'h020}, 20'h00010, 2, 0);    // R7 leaf invalid
    walk({10'd5, 10'd1023, 12'hFFF}, 20'h00010, 0, 0); // R5 reserved bits, R1 top index
    walk({10'd1023, 10'd0, 12'h000}, 20'h00010, 1, 0); // R1 boundary indices
    walk({10'd1, 10'd3, 12'h777}, 20'h00030, 0, 0);    // R2 root select
    walk({10'd1, 10'd3, 12'h123}, 20'h00010, 4, 1);    // R9 poke while busy
    walk({10'd0, 10'd0, 12'h000}, 20'h00030, 0, 0);    // R6 empty root slot

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule